// File: doc/BRIEF.md
# Stimulation Command Decoder

This block sits behind the clock and data recovery of a neural stimulator. It receives one recovered bit per `bit_valid` strobe and watches the bit stream for four fixed 16-bit command words. A configuration command changes how the following bits are used. The next fixed-length block of bits is not searched for commands. It is shifted into a configuration register that holds one current amplitude code for each electrode, plus a reserved field.

The two pulse commands open one phase of a biphasic current pulse, either the cathodic (down) phase or the anodic (up) phase. The phase enable stays high until a stop command arrives. The length of a phase is therefore set only by the external command timing and never by a counter inside the block. A typical session sends a configuration command and its payload, then Pulse-Down, then Stop, then Pulse-Up, then Stop.

The amplitude codes and the two phase enables drive the analog current driver array. That array is outside this block.

Top module: `stim_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the configuration, the shift state and both phase enables after that edge. `phase_up`, `phase_dn`, `amp_codes` and `spare_cfg` then read 0, and the block returns to command hunting.
- R2: Commands are sent most significant bit first. A command is recognised when the last 16 valid bits equal an opcode: Configure 0xA5C3, Pulse-Up 0x5A3C, Pulse-Down 0x3CA5 or Stop 0xC35A. Matching slides bit by bit, so any number of leading bits before an opcode is tolerated.
- R3: A Pulse-Down received while no phase is active sets `phase_dn` from the cycle after its 16th bit. `phase_dn` stays high until a Stop is received, and it is low from the cycle after the Stop's 16th bit.
- R4: A Pulse-Up received while no phase is active sets `phase_up` from the cycle after its 16th bit. It ends on a Stop in the same way as R3.
- R5: `phase_up` and `phase_dn` are never high together. While a phase is active, a Pulse-Up, Pulse-Down or Configure command is ignored and the active phase continues.
- R6: After a Configure received while no phase is active, the next 170 valid bits are payload and are never decoded as commands. Opcode patterns inside the payload have no effect. After the 170th bit, command hunting resumes.
- R7: Let the payload bits be numbered 0 to 169 in arrival order. Electrode k (0 to 14) takes bits 5k to 5k+4, with bit 5k as its most significant bit, and appears on `amp_codes[5k+4:5k]`. Bits 75 to 169 appear on `spare_cfg[94:0]`, with bit 75 at `spare_cfg[94]`. Both outputs change only in the cycle after the 170th bit, and keep their old values until then.
- R8: A 16-bit window that matches no opcode is ignored. After any recognised command, and after the end of a payload, a command needs 16 newly received bits. Bits received before that point never take part in a match. A Stop received while no phase is active has no effect.
- R9: A cycle with `bit_valid` low leaves every output and all internal state unchanged, whatever the value of `bit_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Recovered data bit |
| bit_valid | input | 1 | Strobe: `bit_in` is a new bit this cycle |
| phase_up | output | 1 | Anodic phase enable |
| phase_dn | output | 1 | Cathodic phase enable |
| amp_codes | output | 75 | Fifteen 5-bit amplitude codes; electrode k at bits 5k+4:5k |
| spare_cfg | output | 95 | Reserved configuration bits |

## Verification
The assertions rely on one assumption about the inputs: the block can act only in a cycle that carries a valid bit. Between valid strobes they therefore expect every output to hold. The bench drives each bit as a one-cycle strobe on the falling clock edge, and between strobes it toggles `bit_in` freely with `bit_valid` low, so the hold is actually tested. The bench never asserts reset in the middle of a bit strobe, so the reset checks see a clean idle state. The payload sweeps use arithmetic code patterns, including all-zero and all-31 codes, and they embed real opcodes in the payload to show those bits are never decoded.

// File: rtl/stim_pkg.sv
package stim_pkg;

    localparam int CMD_W = 16;

    localparam logic [CMD_W-1:0] OP_CONFIG = 16'hA5C3;
    localparam logic [CMD_W-1:0] OP_UP     = 16'h5A3C;
    localparam logic [CMD_W-1:0] OP_DOWN   = 16'h3CA5;
    localparam logic [CMD_W-1:0] OP_STOP   = 16'hC35A;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CONFIG,
        CMD_UP,
        CMD_DOWN,
        CMD_STOP
    } cmd_t;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LOAD,
        ST_UP,
        ST_DOWN
    } state_t;

    function automatic cmd_t decode_word(input logic [CMD_W-1:0] w);
        cmd_t c;
        case (w)
            OP_CONFIG: c = CMD_CONFIG;
            OP_UP:     c = CMD_UP;
            OP_DOWN:   c = CMD_DOWN;
            OP_STOP:   c = CMD_STOP;
            default:   c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stim_word_hunter.sv
module stim_word_hunter
    import stim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_valid,
    input  logic hunt_en,
    output cmd_t cmd
);
    localparam int FILL_W = $clog2(CMD_W + 1);

    logic [CMD_W-2:0]  window_q;
    logic [FILL_W-1:0] fill_q;
    logic [CMD_W-1:0]  word_nxt;
    logic              enough;
    logic              take;

    assign word_nxt = {window_q, bit_in};
    assign enough   = (fill_q >= FILL_W'(CMD_W - 1));
    assign take     = bit_valid && hunt_en;

    always_comb begin
        cmd = CMD_NONE;
        if (take && enough) begin
            cmd = decode_word(word_nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            window_q <= '0;
            fill_q   <= '0;
        end else if (take) begin
            window_q <= word_nxt[CMD_W-2:0];
            if (cmd != CMD_NONE) begin
                fill_q <= '0;
            end else if (!enough) begin
                fill_q <= fill_q + 1'b1;
            end
        end else if (bit_valid && !hunt_en) begin
            fill_q <= '0;
        end
    end
endmodule

// File: rtl/stim_cfg_loader.sv
module stim_cfg_loader #(
    parameter int N_ELEC       = 15,
    parameter int AMP_W        = 5,
    parameter int PAYLOAD_BITS = 170
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  bit_in,
    input  logic                                  bit_valid,
    input  logic                                  load_en,
    output logic                                  load_done,
    output logic [N_ELEC*AMP_W-1:0]               amp_codes,
    output logic [PAYLOAD_BITS-N_ELEC*AMP_W-1:0]  spare_cfg
);
    localparam int AMP_BITS   = N_ELEC * AMP_W;
    localparam int SPARE_BITS = PAYLOAD_BITS - AMP_BITS;
    localparam int CNT_W      = $clog2(PAYLOAD_BITS);

    logic [PAYLOAD_BITS-2:0] shift_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [PAYLOAD_BITS-1:0] frame_nxt;
    logic [AMP_BITS-1:0]     amp_nxt;
    logic                    take;

    assign take      = bit_valid && load_en;
    assign frame_nxt = {shift_q, bit_in};
    assign load_done = take && (cnt_q == CNT_W'(PAYLOAD_BITS - 1));

    for (genvar k = 0; k < N_ELEC; k++) begin : g_elec
        assign amp_nxt[k*AMP_W +: AMP_W] =
            frame_nxt[PAYLOAD_BITS-1-k*AMP_W -: AMP_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            cnt_q     <= '0;
            amp_codes <= '0;
            spare_cfg <= '0;
        end else if (take) begin
            shift_q <= frame_nxt[PAYLOAD_BITS-2:0];
            if (load_done) begin
                cnt_q     <= '0;
                amp_codes <= amp_nxt;
                spare_cfg <= frame_nxt[SPARE_BITS-1:0];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stim_phase_fsm.sv
module stim_phase_fsm
    import stim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic load_done,
    output logic hunt_en,
    output logic load_en,
    output logic phase_up,
    output logic phase_dn
);
    state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_HUNT: begin
                case (cmd)
                    CMD_CONFIG: state_d = ST_LOAD;
                    CMD_UP:     state_d = ST_UP;
                    CMD_DOWN:   state_d = ST_DOWN;
                    default:    state_d = ST_HUNT;
                endcase
            end
            ST_LOAD: if (load_done) state_d = ST_HUNT;
            ST_UP, ST_DOWN: if (cmd == CMD_STOP) state_d = ST_HUNT;
            default: state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    assign load_en  = (state_q == ST_LOAD);
    assign hunt_en  = !load_en;
    assign phase_up = (state_q == ST_UP);
    assign phase_dn = (state_q == ST_DOWN);
endmodule

// File: rtl/stim_cmd_decoder.sv
module stim_cmd_decoder
    import stim_pkg::*;
#(
    parameter int N_ELEC       = 15,
    parameter int AMP_W        = 5,
    parameter int PAYLOAD_BITS = 170
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 bit_in,
    input  logic                                 bit_valid,
    output logic                                 phase_up,
    output logic                                 phase_dn,
    output logic [N_ELEC*AMP_W-1:0]              amp_codes,
    output logic [PAYLOAD_BITS-N_ELEC*AMP_W-1:0] spare_cfg
);
    cmd_t cmd;
    logic hunt_en;
    logic load_en;
    logic load_done;

    stim_word_hunter hunter_i (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .hunt_en   (hunt_en),
        .cmd       (cmd)
    );

    stim_cfg_loader #(
        .N_ELEC       (N_ELEC),
        .AMP_W        (AMP_W),
        .PAYLOAD_BITS (PAYLOAD_BITS)
    ) loader_i (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .load_en   (load_en),
        .load_done (load_done),
        .amp_codes (amp_codes),
        .spare_cfg (spare_cfg)
    );

    stim_phase_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .load_done (load_done),
        .hunt_en   (hunt_en),
        .load_en   (load_en),
        .phase_up  (phase_up),
        .phase_dn  (phase_dn)
    );
endmodule

// File: rtl/stim_cmd_decoder_chk.sv
module stim_cmd_decoder_chk #(
    parameter int N_ELEC       = 15,
    parameter int AMP_W        = 5,
    parameter int PAYLOAD_BITS = 170
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 bit_valid,
    input logic                                 phase_up,
    input logic                                 phase_dn,
    input logic [N_ELEC*AMP_W-1:0]              amp_codes,
    input logic [PAYLOAD_BITS-N_ELEC*AMP_W-1:0] spare_cfg
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!phase_up && !phase_dn && amp_codes == '0 && spare_cfg == '0));

    a_r5_one_phase: assert property (@(posedge clk) disable iff (rst)
        !(phase_up && phase_dn));

    a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_dn) |-> !phase_up);

    a_r4_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_up) |-> !phase_dn);

    a_r9_hold_phase: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> ($stable(phase_up) && $stable(phase_dn)));

    a_r9_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> ($stable(amp_codes) && $stable(spare_cfg)));

    a_r7_apply_when_idle: assert property (@(posedge clk) disable iff (rst)
        !$stable(amp_codes) |-> (!phase_up && !phase_dn));
endmodule

bind stim_cmd_decoder stim_cmd_decoder_chk #(
    .N_ELEC       (N_ELEC),
    .AMP_W        (AMP_W),
    .PAYLOAD_BITS (PAYLOAD_BITS)
) chk_i (.*);

// File: tb/stim_cmd_decoder_tb.sv
module stim_cmd_decoder_tb_top;
    localparam int NE = 15;
    localparam int AW = 5;
    localparam int PB = 170;
    localparam int AB = NE * AW;
    localparam int SB = PB - AB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic phase_up, phase_dn;
    logic [AB-1:0] amp_codes;
    logic [SB-1:0] spare_cfg;

    int n_chk = 0;
    int n_fail = 0;
    logic [AB-1:0] amp_exp = '0;
    logic [SB-1:0] spare_exp = '0;

    always #5 clk = ~clk;

    stim_cmd_decoder #(.N_ELEC(NE), .AMP_W(AW), .PAYLOAD_BITS(PB)) dut_i (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
        .phase_up(phase_up), .phase_dn(phase_dn),
        .amp_codes(amp_codes), .spare_cfg(spare_cfg)
    );

    task automatic check(input logic ok, input string req,
                         input logic [PB-1:0] act, input logic [PB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_phase(input string req, input logic up, input logic dn);
        check(phase_up === up && phase_dn === dn, req,
              PB'({phase_up, phase_dn}), PB'({up, dn}));
    endtask

    task automatic check_cfg(input string req);
        for (int k = 0; k < NE; k++) begin
            check(amp_codes[k*AW +: AW] === amp_exp[k*AW +: AW], req,
                  PB'(amp_codes[k*AW +: AW]), PB'(amp_exp[k*AW +: AW]));
        end
        check(spare_cfg === spare_exp, req, PB'(spare_cfg), PB'(spare_exp));
    endtask

    // one valid bit, then one idle cycle with bit_in scrambled
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = ~b;
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) send_bit(w[i]);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_bits(w, 16);
    endtask

    task automatic idle_noise(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_in = i[0] ^ i[2];
        end
    endtask

    task automatic do_config(input int mode, input logic [SB-1:0] spare, input string req);
        logic [PB-1:0] frame;
        logic [AW-1:0] c;
        for (int k = 0; k < NE; k++) begin
            case (mode)
                0: c = AW'((k * 7 + 3) % 32);
                1: c = '1;
                2: c = '0;
                default: c = AW'(31 - 2 * k);
            endcase
            frame[PB-1-k*AW -: AW] = c;
        end
        frame[SB-1:0] = spare;
        send_word(16'hA5C3);
        for (int i = PB - 1; i > 0; i--) send_bit(frame[i]);
        check_cfg({req, " R7 held before last bit"});
        send_bit(frame[0]);
        for (int k = 0; k < NE; k++) amp_exp[k*AW +: AW] = frame[PB-1-k*AW -: AW];
        spare_exp = spare;
        check_cfg({req, " R7 applied"});
        check_phase({req, " R6 payload opcodes ignored"}, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_phase("R1 reset phases", 1'b0, 1'b0);
        check_cfg("R1 reset config");

        send_word(16'hC35A);
        check_phase("R8 stop while idle", 1'b0, 1'b0);
        send_word(16'h1234);
        check_phase("R8 unknown word", 1'b0, 1'b0);

        send_bits(16'h3CA5, 15);
        check_phase("R3 15 bits not enough", 1'b0, 1'b0);
        send_bit(1'b1);
        check_phase("R3 pulse-down set", 1'b0, 1'b1);
        send_word(16'h5A3C);
        check_phase("R5 pulse-up ignored while down", 1'b0, 1'b1);
        send_word(16'hA5C3);
        check_phase("R5 configure ignored while down", 1'b0, 1'b1);
        idle_noise(40);
        check_phase("R9 idle noise holds phase", 1'b0, 1'b1);
        send_bits(16'hC35A, 15);
        check_phase("R3 held until stop complete", 1'b0, 1'b1);
        send_bit(1'b0);
        check_phase("R3 stop ends down", 1'b0, 1'b0);

        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_word(16'h5A3C);
        check_phase("R2 R4 sliding match pulse-up", 1'b1, 1'b0);
        send_word(16'h3CA5);
        check_phase("R5 pulse-down ignored while up", 1'b1, 1'b0);
        send_word(16'hC35A);
        check_phase("R4 stop ends up", 1'b0, 1'b0);

        // window now ends in a 0: 15 more bits would spell 0x5A3C
        send_bits(16'hB478, 15);
        check_phase("R8 stale bit not used", 1'b0, 1'b0);
        send_word(16'hC35A);

        do_config(0, {15'h1F0F, 16'h5A3C, 32'hDEADBEEF, 32'h5A3C3CA5}, "cfg0");
        send_word(16'h3CA5);
        check_phase("R6 hunting resumes after payload", 1'b0, 1'b1);
        send_word(16'hC35A);
        check_phase("R3 stop", 1'b0, 1'b0);

        do_config(1, '1, "cfg1");
        do_config(2, '0, "cfg2");
        do_config(3, {31'h3CA53CA5, 32'hA5C3A5C3, 32'h0F0F1234}, "cfg3");
        idle_noise(30);
        check_cfg("R9 idle noise holds config");

        send_word(16'h5A3C);
        check_phase("R4 pulse-up before reset", 1'b1, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        amp_exp = '0;
        spare_exp = '0;
        check_phase("R1 reset mid-pulse", 1'b0, 1'b0);
        check_cfg("R1 reset clears config");
        send_word(16'h3CA5);
        check_phase("R1 hunting after reset", 1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule